// File: doc/BRIEF.md
# CKE-Gated Column Burst Engine

This block sequences column bursts for a synchronous DRAM-style device. Commands arrive on active-low select, row-strobe, column-strobe and write-enable pins together with a bank and a column address, and they are sampled on the rising clock edge. A read or write command starts a burst of 1, 2, 4 or 8 beats over consecutive columns. The column count wraps inside the block of columns aligned to the burst length. The beats address a small internal register file. A write burst stores one data word per beat. A read burst drives one word per beat on a registered output, together with an output-enable.

A clock-enable input gives the clock-suspend behaviour. If an edge samples the enable low while beats of a burst are still pending, the next internal edge is suspended. At a suspended edge the counter holds and commands and write data are ignored. The read output, its enable and the reported column also hold. The burst resumes one edge after the enable is sampled high again. A write word that was offered at a suspended edge must be offered again.

Top module: `cke_burst_engine`

## Requirements
- R1: After reset, `rdata_oe` and `wr_strobe` are low, `col_out` and `rdata` are zero, the burst length is 1 and every storage word reads as zero.
- R2: Commands are decoded from {`cs_n`,`ras_n`,`cas_n`,`we_n`} as follows: 0101 is read, 0100 is write, 0000 is mode set, and any other value, including `cs_n` high, does nothing. A mode set takes the burst length from `addr[1:0]` (0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8). A mode set is ignored while burst beats are pending.
- R3: A write command stores `wdata` at the commanded bank and column on the command edge itself. Each later active beat edge stores `wdata` at the next column. In the cycle after each stored beat, `wr_strobe` is high and `col_out` shows the column that was written.
- R4: A read command drives the stored word of the commanded column on `rdata`, with `rdata_oe` high, in the cycle after the command edge, and then one word per active beat edge. `rdata_oe` falls after the first active edge that follows the last beat.
- R5: Within a burst the column advances by one and wraps inside the block of columns aligned to the burst length. With length 4 from column 6 the order is 6,7,4,5. With length 8 from column 13 the order is 13,14,15,8,9,10,11,12.
- R6: A burst consists of exactly the programmed number of beats. Suspended edges are not counted. After the last beat the engine is idle.
- R7: Each edge that samples `cke` low while beats are pending suspends the following edge, so consecutive low samples suspend consecutive edges. Sampling `cke` high ends the suspension from the next edge on.
- R8: At a suspended edge, commands and `wdata` are ignored: nothing is stored, `wr_strobe` is low in the following cycle, and the burst does not restart.
- R9: Across a suspended edge, `rdata`, `rdata_oe` and `col_out` keep their values.
- R10: Sampling `cke` low while no beats are pending causes no suspension. A command at the next edge is accepted and runs normally.
- R11: A read or write command at an active edge during a burst abandons the remaining beats and starts a new burst at its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable, sampled each rising edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank | input | BANK_W | Bank address of a column command |
| addr | input | COL_W | Column address; bits 1:0 carry the burst-length code of a mode set |
| wdata | input | DATA_W | Write data for the current beat |
| col_out | output | COL_W | Column of the most recent beat |
| wr_strobe | output | 1 | High for one cycle after each stored write beat |
| rdata | output | DATA_W | Read data of the most recent read beat |
| rdata_oe | output | 1 | Read output enable |

## Verification
The hardest case to reach is a suspended edge that carries a live command and changed write data in the middle of a write burst. The stimulus drives `cke` low on a beat and offers a new write command with a junk word on the next edge. It then checks that the strobe drops, that the column does not restart, and that a later read-back shows the re-offered word rather than the junk. Further directed scenarios cover two consecutive low samples during a read, `cke` held low from idle into a command, and a burst-length change tried during a burst. Each scenario uses cycle-exact expectations worked out from the requirements.

// File: rtl/cbe_pkg.sv
package cbe_pkg;

   typedef enum logic [1:0] {
      CMD_NOP   = 2'd0,
      CMD_READ  = 2'd1,
      CMD_WRITE = 2'd2,
      CMD_MODE  = 2'd3
   } cmd_e;

   // Active-low strobes: read 0101, write 0100, mode set 0000
   function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                       input logic cas_n, input logic we_n);
      cmd_e c;
      c = CMD_NOP;
      if (!cs_n) begin
         case ({ras_n, cas_n, we_n})
            3'b101:  c = CMD_READ;
            3'b100:  c = CMD_WRITE;
            3'b000:  c = CMD_MODE;
            default: c = CMD_NOP;
         endcase
      end
      return c;
   endfunction

endpackage

// File: rtl/cbe_edge_gate.sv
module cbe_edge_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic cke,
   input  logic pending,
   output logic susp_q,
   output logic edge_en
);

   // A low CKE sample with beats pending freezes the next edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) susp_q <= 1'b0;
      else        susp_q <= ~cke & pending;
   end

   assign edge_en = ~susp_q;

endmodule

// File: rtl/cbe_burst_seq.sv
module cbe_burst_seq
   import cbe_pkg::*;
#(
   parameter int BANK_W = 2,
   parameter int COL_W  = 4,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              edge_en,
   input  cmd_e              cmd,
   input  logic [BANK_W-1:0] bank_i,
   input  logic [COL_W-1:0]  col_i,
   output logic              beat_valid,
   output logic              beat_write,
   output logic [BANK_W-1:0] beat_bank,
   output logic [COL_W-1:0]  beat_col,
   output logic              pending
);

   logic [1:0]        len_code_q;
   logic              busy_q, busy_n;
   logic              wr_q;
   logic [BANK_W-1:0] bank_q;
   logic [COL_W-1:0]  col_q;
   logic [CNT_W-1:0]  rem_q, rem_n;
   logic [CNT_W-1:0]  beats;
   logic [COL_W-1:0]  wrap_mask;
   logic              start, cont, mode_ld;

   always_comb begin
      beats     = CNT_W'(1) << len_code_q;
      wrap_mask = COL_W'(beats - CNT_W'(1));
      start     = edge_en && (cmd == CMD_READ || cmd == CMD_WRITE);
      cont      = edge_en && busy_q && !start;
      mode_ld   = edge_en && (cmd == CMD_MODE) && !busy_q;

      beat_col   = col_q;
      beat_bank  = bank_q;
      beat_write = wr_q;
      rem_n      = rem_q;
      busy_n     = busy_q;
      if (start) begin
         beat_col   = col_i;
         beat_bank  = bank_i;
         beat_write = (cmd == CMD_WRITE);
         rem_n      = beats - CNT_W'(1);
         busy_n     = (beats != CNT_W'(1));
      end else if (cont) begin
         beat_col = (col_q & ~wrap_mask) | ((col_q + COL_W'(1)) & wrap_mask);
         rem_n    = rem_q - CNT_W'(1);
         busy_n   = (rem_q != CNT_W'(1));
      end
      beat_valid = start | cont;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_code_q <= 2'd0;
         busy_q     <= 1'b0;
         wr_q       <= 1'b0;
         bank_q     <= '0;
         col_q      <= '0;
         rem_q      <= '0;
      end else begin
         if (mode_ld) len_code_q <= col_i[1:0];
         if (beat_valid) begin
            busy_q <= busy_n;
            wr_q   <= beat_write;
            bank_q <= beat_bank;
            col_q  <= beat_col;
            rem_q  <= rem_n;
         end
      end
   end

   assign pending = busy_q;

endmodule

// File: rtl/cbe_regfile.sv
module cbe_regfile #(
   parameter int AW = 6,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int WORDS = 1 << AW;

   logic [DW-1:0] mem_q [WORDS];

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        mem_q[w] <= '0;
         else if (we && waddr == AW'(w))    mem_q[w] <= wdata;
      end
   end

   assign rdata = mem_q[raddr];

endmodule

// File: rtl/cke_burst_engine.sv
module cke_burst_engine
   import cbe_pkg::*;
#(
   parameter int BANK_W = 2,
   parameter int COL_W  = 4,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke,
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [BANK_W-1:0] bank,
   input  logic [COL_W-1:0]  addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [COL_W-1:0]  col_out,
   output logic              wr_strobe,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_oe
);

   localparam int WORD_AW = BANK_W + COL_W;
   localparam int CNT_W   = 4;

   if (COL_W < 3) begin : g_bad_col
      $error("COL_W must hold a burst of eight columns");
   end
   if (WORD_AW > 12) begin : g_bad_size
      $error("storage array too large for this block");
   end
   if (DATA_W < 1 || BANK_W < 1) begin : g_bad_width
      $error("DATA_W and BANK_W must be positive");
   end

   cmd_e              cmd;
   logic              susp_q, edge_en, pending;
   logic              beat_valid, beat_write;
   logic [BANK_W-1:0] beat_bank;
   logic [COL_W-1:0]  beat_col;
   logic [DATA_W-1:0] array_rd;
   logic              array_we;

   assign cmd      = decode_cmd(cs_n, ras_n, cas_n, we_n);
   assign array_we = beat_valid & beat_write;

   cbe_edge_gate u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .cke     (cke),
      .pending (pending),
      .susp_q  (susp_q),
      .edge_en (edge_en)
   );

   cbe_burst_seq #(.BANK_W(BANK_W), .COL_W(COL_W), .CNT_W(CNT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .edge_en    (edge_en),
      .cmd        (cmd),
      .bank_i     (bank),
      .col_i      (addr),
      .beat_valid (beat_valid),
      .beat_write (beat_write),
      .beat_bank  (beat_bank),
      .beat_col   (beat_col),
      .pending    (pending)
   );

   cbe_regfile #(.AW(WORD_AW), .DW(DATA_W)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (array_we),
      .waddr ({beat_bank, beat_col}),
      .wdata (wdata),
      .raddr ({beat_bank, beat_col}),
      .rdata (array_rd)
   );

   // Output stage: frozen on a suspended edge except the write strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_out   <= '0;
         wr_strobe <= 1'b0;
         rdata     <= '0;
         rdata_oe  <= 1'b0;
      end else if (edge_en) begin
         wr_strobe <= array_we;
         if (beat_valid) col_out <= beat_col;
         if (beat_valid && !beat_write) begin
            rdata    <= array_rd;
            rdata_oe <= 1'b1;
         end else begin
            rdata_oe <= 1'b0;
         end
      end else begin
         wr_strobe <= 1'b0;
      end
   end

endmodule

// File: rtl/cbe_checker.sv
module cbe_checker #(
   parameter int COL_W  = 4,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cke,
   input logic              susp_q,
   input logic              pending,
   input logic              wr_strobe,
   input logic              rdata_oe,
   input logic [DATA_W-1:0] rdata,
   input logic [COL_W-1:0]  col_out
);

   p_hold_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
      susp_q |=> ($stable(rdata) && $stable(rdata_oe) && $stable(col_out)));

   p_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      susp_q |=> !wr_strobe);

   p_susp_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      susp_q |-> ($past(!cke) && $past(pending)));

   p_cke_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cke |=> !susp_q);

   p_idle_no_susp_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !pending |=> !susp_q);

   p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_strobe && rdata_oe));

endmodule

bind cke_burst_engine cbe_checker #(.COL_W(COL_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cke       (cke),
   .susp_q    (susp_q),
   .pending   (pending),
   .wr_strobe (wr_strobe),
   .rdata_oe  (rdata_oe),
   .rdata     (rdata),
   .col_out   (col_out)
);

// File: tb/cke_burst_engine_tb.sv
`timescale 1ns/1ps
module cke_burst_engine_tb;

   localparam logic [3:0] K_NOP = 4'b0111;
   localparam logic [3:0] K_RD  = 4'b0101;
   localparam logic [3:0] K_WR  = 4'b0100;
   localparam logic [3:0] K_MS  = 4'b0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cke = 1'b1;
   logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0]  bank = '0;
   logic [3:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [3:0]  col_out;
   logic        wr_strobe;
   logic [15:0] rdata;
   logic        rdata_oe;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [15:0] mm [64];

   always #2 clk = ~clk;

   cke_burst_engine u_dut (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .bank(bank), .addr(addr), .wdata(wdata),
      .col_out(col_out), .wr_strobe(wr_strobe), .rdata(rdata), .rdata_oe(rdata_oe)
   );

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic step(input logic c, input logic [3:0] k, input logic [1:0] b,
                       input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      cke = c; {cs_n, ras_n, cas_n, we_n} = k; bank = b; addr = a; wdata = d;
      @(posedge clk);
      #1;
   endtask

   task automatic chk_rd(input string tag, input logic [15:0] d, input logic [3:0] col);
      chk({tag, " oe"}, 32'(rdata_oe), 32'd1);
      chk({tag, " rdata"}, 32'(rdata), 32'(d));
      chk({tag, " col"}, 32'(col_out), 32'(col));
   endtask

   task automatic chk_wr(input string tag, input logic s, input logic [3:0] col);
      chk({tag, " strobe"}, 32'(wr_strobe), 32'(s));
      chk({tag, " col"}, 32'(col_out), 32'(col));
   endtask

   task automatic t_reset();
      chk("R1 oe", 32'(rdata_oe), 32'd0);
      chk("R1 strobe", 32'(wr_strobe), 32'd0);
      chk("R1 col", 32'(col_out), 32'd0);
      chk("R1 rdata", 32'(rdata), 32'd0);
      step(1, K_RD, 2'd0, 4'd3, '0);
      chk_rd("R1 zero word", 16'h0, 4'd3);
      step(1, K_NOP, 0, 0, '0);
      chk("R1/R6 length one", 32'(rdata_oe), 32'd0);
   endtask

   task automatic t_write_basic();
      logic [3:0] cols [4] = '{4'd6, 4'd7, 4'd4, 4'd5};
      step(1, K_MS, 0, 4'd2, '0);
      step(1, K_WR, 2'd1, 4'd6, 16'h1100);
      mm[{2'd1, 4'd6}] = 16'h1100;
      chk_wr("R3 beat0", 1'b1, 4'd6);
      for (int i = 1; i < 4; i++) begin
         step(1, K_NOP, 0, 0, 16'h1100 + 16'(i));
         mm[{2'd1, cols[i]}] = 16'h1100 + 16'(i);
         chk_wr("R3/R5 write beat", 1'b1, cols[i]);
      end
      step(1, K_NOP, 0, 0, 16'hFFFF);
      chk("R6 write ends", 32'(wr_strobe), 32'd0);
   endtask

   task automatic t_read_basic();
      logic [3:0] cols [4] = '{4'd6, 4'd7, 4'd4, 4'd5};
      step(1, K_RD, 2'd1, 4'd6, '0);
      chk_rd("R4 beat0", mm[{2'd1, 4'd6}], 4'd6);
      for (int i = 1; i < 4; i++) begin
         step(1, K_NOP, 0, 0, '0);
         chk_rd("R4/R5 read beat", mm[{2'd1, cols[i]}], cols[i]);
      end
      step(1, K_NOP, 0, 0, '0);
      chk("R4/R6 oe falls", 32'(rdata_oe), 32'd0);
   endtask

   task automatic t_write_susp();
      step(1, K_WR, 2'd2, 4'd0, 16'h2200);
      mm[{2'd2, 4'd0}] = 16'h2200;
      chk_wr("R3 susp beat0", 1'b1, 4'd0);
      step(0, K_NOP, 0, 0, 16'h2201);
      mm[{2'd2, 4'd1}] = 16'h2201;
      chk_wr("R7 low-sample edge active", 1'b1, 4'd1);
      step(1, K_WR, 2'd2, 4'd9, 16'hDEAD);
      chk_wr("R8 suspended write ignored", 1'b0, 4'd1);
      step(1, K_NOP, 0, 0, 16'h2202);
      mm[{2'd2, 4'd2}] = 16'h2202;
      chk_wr("R7/R8 resume no restart", 1'b1, 4'd2);
      step(1, K_NOP, 0, 0, 16'h2203);
      mm[{2'd2, 4'd3}] = 16'h2203;
      chk_wr("R6 last beat", 1'b1, 4'd3);
      step(1, K_NOP, 0, 0, '0);
      chk("R6 suspended write ends", 32'(wr_strobe), 32'd0);
      step(1, K_RD, 2'd2, 4'd9, '0);
      chk_rd("R8 command at suspended edge stored nothing", 16'h0, 4'd9);
      for (int i = 0; i < 4; i++) begin
         step(1, K_NOP, 0, 0, '0);
      end
   endtask

   task automatic t_read_susp();
      step(1, K_RD, 2'd2, 4'd0, '0);
      chk_rd("R4 readback", 16'h2200, 4'd0);
      step(0, K_NOP, 0, 0, '0);
      chk_rd("R8 re-presented word stored", 16'h2201, 4'd1);
      step(0, K_NOP, 0, 0, '0);
      chk_rd("R9 hold first suspend", 16'h2201, 4'd1);
      step(1, K_NOP, 0, 0, '0);
      chk_rd("R7/R9 second low sample suspends", 16'h2201, 4'd1);
      step(1, K_NOP, 0, 0, '0);
      chk_rd("R7 resume", 16'h2202, 4'd2);
      step(1, K_NOP, 0, 0, '0);
      chk_rd("R6 last read beat", 16'h2203, 4'd3);
      step(1, K_NOP, 0, 0, '0);
      chk("R6 read ends after suspend", 32'(rdata_oe), 32'd0);
   endtask

   task automatic t_idle_low();
      step(0, K_NOP, 0, 0, '0);
      step(0, K_RD, 2'd2, 4'd0, '0);
      chk_rd("R10 command accepted with cke low", 16'h2200, 4'd0);
      step(0, K_NOP, 0, 0, '0);
      chk_rd("R10 edge after idle low not suspended", 16'h2201, 4'd1);
      step(1, K_NOP, 0, 0, '0);
      chk_rd("R7 suspended once busy", 16'h2201, 4'd1);
      step(1, K_NOP, 0, 0, '0);
      chk_rd("R10 resume", 16'h2202, 4'd2);
      step(1, K_NOP, 0, 0, '0);
      step(1, K_NOP, 0, 0, '0);
      chk("R10 ends", 32'(rdata_oe), 32'd0);
   endtask

   task automatic t_restart();
      step(1, K_RD, 2'd1, 4'd6, '0);
      chk_rd("R11 first burst", 16'h1100, 4'd6);
      step(1, K_RD, 2'd2, 4'd2, '0);
      chk_rd("R11 restart", 16'h2202, 4'd2);
      step(1, K_NOP, 0, 0, '0);
      chk_rd("R11 beat1", 16'h2203, 4'd3);
      step(1, K_NOP, 0, 0, '0);
      chk_rd("R11/R5 wrap", 16'h2200, 4'd0);
      step(1, K_NOP, 0, 0, '0);
      chk_rd("R11 beat3", 16'h2201, 4'd1);
      step(1, K_NOP, 0, 0, '0);
      chk("R11 ends", 32'(rdata_oe), 32'd0);
   endtask

   task automatic t_mode_busy();
      step(1, K_RD, 2'd2, 4'd0, '0);
      step(1, K_MS, 0, 4'd0, '0);
      chk_rd("R2 mode set during burst", 16'h2201, 4'd1);
      step(1, K_NOP, 0, 0, '0);
      step(1, K_NOP, 0, 0, '0);
      chk_rd("R2 burst unchanged", 16'h2203, 4'd3);
      step(1, K_NOP, 0, 0, '0);
      step(1, K_RD, 2'd1, 4'd6, '0);
      step(1, K_NOP, 0, 0, '0);
      chk_rd("R2 length stays 4", 16'h1101, 4'd7);
      for (int i = 0; i < 3; i++) begin
         step(1, K_NOP, 0, 0, '0);
      end
   endtask

   task automatic t_len8_len2();
      logic [3:0] cols [8] = '{4'd13, 4'd14, 4'd15, 4'd8, 4'd9, 4'd10, 4'd11, 4'd12};
      step(1, K_MS, 0, 4'd3, '0);
      for (int i = 0; i < 8; i++) begin
         step(1, (i == 0) ? K_WR : K_NOP, 2'd3, 4'd13, 16'h3300 + 16'(i));
         mm[{2'd3, cols[i]}] = 16'h3300 + 16'(i);
         chk_wr("R5 length-8 wrap", 1'b1, cols[i]);
      end
      step(1, K_NOP, 0, 0, '0);
      chk("R6 length 8 ends", 32'(wr_strobe), 32'd0);
      step(1, K_MS, 0, 4'd1, '0);
      step(1, K_RD, 2'd3, 4'd9, '0);
      chk_rd("R2 length 2 beat0", 16'h3304, 4'd9);
      step(1, K_NOP, 0, 0, '0);
      chk_rd("R5 length 2 wrap", 16'h3303, 4'd8);
      step(1, K_NOP, 0, 0, '0);
      chk("R6 length 2 ends", 32'(rdata_oe), 32'd0);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) mm[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_write_basic();
      t_read_basic();
      t_write_susp();
      t_read_susp();
      t_idle_low();
      t_restart();
      t_mode_busy();
      t_len8_len2();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule